// File: doc/BRIEF.md
# Indexed Block Configuration Register Target on a Two-Wire Serial Bus

This block is a two-wire serial bus target (I2C protocol, open-drain data modelled as `sda_in` plus an active-high pull-down enable `sda_oe`). It gives a host access to a bank of 8-bit configuration registers. Every transfer is a block transfer. A write carries a start index, then a byte count, then that many data bytes. A read first sets the index with a short write, then issues a repeated start with the read address. The target answers with the contents of a programmable count register and then streams registers from the index upward until the host declines a byte.

The core clock oversamples both bus lines. Bytes move through a single shift register, and a small state machine sequences the address, index, count, data and acknowledge phases. The whole bank is presented in parallel to the rest of the device. A few entries are fixed identity values or captured strap pins. A group of frequency-related entries is withheld from the parallel port until a programming-enable bit is set.

Top module: `i2c_blk_regs`

## Requirements
- R1: Only the 7-bit address 0x69 is acknowledged: byte 0xD2 selects a write and 0xD3 selects a read. Any other address byte is not acknowledged, and the target then leaves SDA released until the next start or stop.
- R2: A write transaction is the address byte, then start index N, then count X, then data bytes. The first X data bytes go to registers N, N+1 and so on, and the target acknowledges every byte.
- R3: Data bytes sent after X bytes in the same write are acknowledged and discarded, leaving every register unchanged.
- R4: After a write of the address and index, a repeated start with 0xD3 makes the target send the value of register 8 first. It then sends registers N, N+1 and so on, one per host acknowledge, until the host does not acknowledge. After that the target releases SDA.
- R5: After reset, register 8 is 0x0F, register 1 bits 7:5 are 1, and every other writable register is 0x00.
- R6: Register 6 reads {revision parameter, 4'b0001} (0x01 by default) and register 7 reads 0x22. Writes to both are ignored.
- R7: Register 1 bits 4:0 read the strap inputs as captured while reset is asserted. Later strap changes and writes to those bits have no effect, while bits 7:5 stay writable.
- R8: Indices at or above the number of registers (24 by default) read 0x00 and ignore writes. The index still advances past them.
- R9: `cfg_o` byte i carries the read value of register i. Registers 0 and 11 to 17 are shown as 0x00 on `cfg_o` while register 10 bit 7 is 0.
- R10: A stop or a start anywhere in a transaction abandons it. Bytes completed before that point stay written, a partial byte is dropped, a start begins a fresh address phase, and the index is kept.
- R11: `sda_oe` only asserts while SCL is low, and is low after every stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, oversamples the bus |
| rst_n | input | 1 | Active-low reset; straps are captured while low |
| scl_in | input | 1 | Serial clock from the bus |
| sda_in | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap_i | input | 5 | Strap levels to capture at reset |
| cfg_o | output | 8*NREG | Parallel register image, byte i is register i |

## Verification
The assertions take for granted that the host changes SDA only while SCL is low, except to form a start or a stop. They also assume that each SCL phase lasts several core clocks, so the two-flop synchronizers never merge an edge with a data change. The stimulus holds every level for a quarter of an SCL bit of six core clocks and drives the data line a quarter period after SCL falls. Random block writes and reads stay inside the index range the bench model covers, and the abort cases place a stop or start only while SCL is high with the target not driving SDA.

// File: rtl/i2c_blk_regs.sv
module i2c_blk_regs #(
  parameter int         NREG      = 24,
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter logic [7:0] DEVICE_ID = 8'h22,
  parameter logic [3:0] REV_ID    = 4'h0,
  parameter logic [7:0] CNT_RESET = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic [4:0]        strap_i,
  output logic [8*NREG-1:0] cfg_o
);

  localparam int AW        = $clog2(NREG);
  localparam int STRAP_IDX = 1;
  localparam int VID_IDX   = 6;
  localparam int DID_IDX   = 7;
  localparam int CNT_IDX   = 8;
  localparam int CTL_IDX   = 10;
  localparam int GATE_LO   = 11;
  localparam int GATE_HI   = 17;
  localparam logic [3:0] VENDOR = 4'b0001;

  localparam logic [2:0] IDLE = 3'd0, RXB = 3'd1, RACK = 3'd2, TXB = 3'd3,
                         TACK = 3'd4, TNXT = 3'd5, WAIT = 3'd6;
  localparam logic [1:0] P_ADDR = 2'd0, P_IDX = 2'd1, P_CNT = 2'd2, P_DATA = 2'd3;

  logic [1:0] scl_ff, sda_ff;
  logic       scl_p, sda_p;
  logic       scl_s, sda_s;
  logic       start_det, stop_det, scl_rise, scl_fall;

  logic [2:0] st;
  logic [1:0] ph;
  logic [3:0] bcnt;
  logic [7:0] sh, idx, wcnt;
  logic       rw;
  logic [4:0] strap_q;
  logic [7:0] rf [NREG];
  logic [7:0] cnt_now, rd_now;
  logic       prog_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_in};
      sda_ff <= {sda_ff[0], sda_in};
      scl_p  <= scl_ff[1];
      sda_p  <= sda_ff[1];
    end
  end

  assign scl_s     = scl_ff[1];
  assign sda_s     = sda_ff[1];
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;

  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= strap_i;
  end

  function automatic logic [7:0] reset_val(input int i);
    if (i == CNT_IDX)   return CNT_RESET;
    if (i == STRAP_IDX) return 8'hE0;
    return 8'h00;
  endfunction

  function automatic logic wr_ok(input logic [7:0] i);
    return int'(i) < NREG && int'(i) != VID_IDX && int'(i) != DID_IDX;
  endfunction

  function automatic logic [7:0] rd_reg(input logic [7:0] i);
    if (int'(i) >= NREG)      return 8'h00;
    if (int'(i) == VID_IDX)   return {REV_ID, VENDOR};
    if (int'(i) == DID_IDX)   return DEVICE_ID;
    if (int'(i) == STRAP_IDX) return {rf[STRAP_IDX][7:5], strap_q};
    return rf[i[AW-1:0]];
  endfunction

  assign cnt_now = rd_reg(8'(CNT_IDX));
  assign rd_now  = rd_reg(idx);
  assign prog_en = rf[CTL_IDX][7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      ph     <= P_ADDR;
      bcnt   <= '0;
      sh     <= '0;
      idx    <= '0;
      wcnt   <= '0;
      rw     <= 1'b0;
      sda_oe <= 1'b0;
      for (int i = 0; i < NREG; i++) rf[i] <= reset_val(i);
    end else if (start_det) begin
      st     <= RXB;
      ph     <= P_ADDR;
      bcnt   <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      st     <= IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        RXB: begin
          if (scl_rise && bcnt < 4'd8) begin
            sh   <= {sh[6:0], sda_s};
            bcnt <= bcnt + 4'd1;
          end else if (scl_fall && bcnt == 4'd8) begin
            st     <= RACK;
            sda_oe <= 1'b1;
            case (ph)
              P_ADDR: begin
                if (sh[7:1] == DEV_ADDR) rw <= sh[0];
                else begin
                  st     <= WAIT;
                  sda_oe <= 1'b0;
                end
              end
              P_IDX: idx <= sh;
              P_CNT: wcnt <= sh;
              default: begin
                if (wcnt != 8'd0) begin
                  if (wr_ok(idx)) rf[idx[AW-1:0]] <= sh;
                  idx  <= idx + 8'd1;
                  wcnt <= wcnt - 8'd1;
                end
              end
            endcase
          end
        end
        RACK: begin
          if (scl_fall) begin
            bcnt <= '0;
            if (ph == P_ADDR && rw) begin
              st     <= TXB;
              sh     <= cnt_now;
              sda_oe <= ~cnt_now[7];
            end else begin
              st     <= RXB;
              sda_oe <= 1'b0;
              if (ph != P_DATA) ph <= ph + 2'd1;
            end
          end
        end
        TXB: begin
          if (scl_fall) begin
            if (bcnt == 4'd7) begin
              st     <= TACK;
              sda_oe <= 1'b0;
            end else begin
              sh     <= {sh[6:0], 1'b0};
              sda_oe <= ~sh[6];
              bcnt   <= bcnt + 4'd1;
            end
          end
        end
        TACK: if (scl_rise) st <= sda_s ? WAIT : TNXT;
        TNXT: begin
          if (scl_fall) begin
            sh     <= rd_now;
            sda_oe <= ~rd_now[7];
            idx    <= idx + 8'd1;
            bcnt   <= '0;
            st     <= TXB;
          end
        end
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_cfg
    if (g == 0 || (g >= GATE_LO && g <= GATE_HI)) begin : g_gated
      assign cfg_o[8*g +: 8] = prog_en ? rd_reg(8'(g)) : 8'h00;
    end else begin : g_plain
      assign cfg_o[8*g +: 8] = rd_reg(8'(g));
    end
  end

endmodule

// File: rtl/i2c_blk_regs_chk.sv
module i2c_blk_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_oe,
  input logic [2:0] st,
  input logic [3:0] bcnt,
  input logic       start_det,
  input logic       stop_det,
  input logic [4:0] strap_q
);

  // R11
  oe_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_s));

  // R10
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == 3'd0 && !sda_oe));

  // R10
  start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == 3'd1 && bcnt == 4'd0 && !sda_oe));

  // R1
  nack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd6) |-> !sda_oe);

  // R7
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(strap_q));

  // R2
  bit_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt <= 4'd8);

endmodule

bind i2c_blk_regs i2c_blk_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .st(st),
  .bcnt(bcnt), .start_det(start_det), .stop_det(stop_det), .strap_q(strap_q)
);

// File: tb/sim_i2c_blk_regs.sv
module sim_i2c_blk_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 24;
  localparam int Q  = 6;
  localparam logic [4:0] STRAP0 = 5'b10110;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_h = 1'b1;
  logic sda_oe, sda_line;
  logic [4:0] strap = STRAP0;
  logic [8*NR-1:0] cfg_o;

  assign sda_line = sda_oe ? 1'b0 : sda_h;

  i2c_blk_regs #(.NREG(NR)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .strap_i(strap), .cfg_o(cfg_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  logic [7:0] mdl [NR];
  logic [7:0] wbuf [8];

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input int i);
    if (i >= NR) return 8'h00;
    if (i == 6) return 8'h01;
    if (i == 7) return 8'h22;
    if (i == 1) return {mdl[1][7:5], STRAP0};
    return mdl[i];
  endfunction

  function automatic logic [7:0] exp_cfg(input int i);
    if ((i == 0 || (i >= 11 && i <= 17)) && !mdl[10][7]) return 8'h00;
    return exp_rd(i);
  endfunction

  task automatic model_wr(input int i, input logic [7:0] d);
    if (i < NR && i != 6 && i != 7) mdl[i] = d;
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_h = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_h = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop;
    sda_h = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_h = 1'b1; wq(2*Q);
  endtask

  task automatic put_bit(input logic b);
    sda_h = b; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_h = 1'b1; wq(Q); scl = 1'b1; wq(Q); b = sda_line; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic put_byte(input logic [7:0] d, output bit ack);
    logic b;
    for (int k = 7; k >= 0; k--) put_bit(d[k]);
    get_bit(b);
    ack = !b;
  endtask

  task automatic get_byte(output logic [7:0] d, input logic last);
    logic b;
    for (int k = 7; k >= 0; k--) begin
      get_bit(b);
      d[k] = b;
    end
    put_bit(last);
  endtask

  task automatic do_write(input int idx, input int n, input int nsend, input string tag);
    bit a;
    bus_start;
    put_byte(8'hD2, a); chk(a, {tag, " R1 write address ack"}, 8'(a), 8'h01);
    put_byte(8'(idx), a); chk(a, {tag, " R2 index ack"}, 8'(a), 8'h01);
    put_byte(8'(n), a);   chk(a, {tag, " R2 count ack"}, 8'(a), 8'h01);
    for (int k = 0; k < nsend; k++) begin
      put_byte(wbuf[k], a);
      chk(a, {tag, " R2 R3 data ack"}, 8'(a), 8'h01);
      if (k < n) model_wr(idx + k, wbuf[k]);
    end
    bus_stop;
    chk(!sda_oe, {tag, " R11 released after stop"}, 8'(sda_oe), 8'h00);
  endtask

  task automatic do_read(input int idx, input int n, input string tag);
    bit a;
    logic [7:0] d;
    bus_start;
    put_byte(8'hD2, a);
    put_byte(8'(idx), a);
    bus_start;
    put_byte(8'hD3, a); chk(a, {tag, " R1 read address ack"}, 8'(a), 8'h01);
    get_byte(d, n == 0);
    chk(d == mdl[8], {tag, " R4 count byte"}, d, mdl[8]);
    for (int k = 0; k < n; k++) begin
      get_byte(d, k == n - 1);
      chk(d == exp_rd(idx + k), {tag, " R4 R6 R8 data byte"}, d, exp_rd(idx + k));
    end
    bus_stop;
    chk(!sda_oe, {tag, " R11 released after read"}, 8'(sda_oe), 8'h00);
  endtask

  task automatic chk_cfg(input string tag);
    for (int i = 0; i < NR; i++)
      chk(cfg_o[8*i +: 8] == exp_cfg(i), {tag, " R9 parallel byte"}, cfg_o[8*i +: 8], exp_cfg(i));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NR; i++) mdl[i] = (i == 8) ? 8'h0F : (i == 1) ? 8'hE0 : 8'h00;
    wq(10);
    rst_n = 1'b1;
    wq(4);
    strap = 5'b01001;
    wq(4);

    // R5 R7 reset state on the parallel port
    chk(cfg_o[8*8 +: 8] == 8'h0F, "R5 count reset", cfg_o[8*8 +: 8], 8'h0F);
    chk(cfg_o[8*1 +: 8] == {3'b111, STRAP0}, "R7 strap capture", cfg_o[8*1 +: 8], {3'b111, STRAP0});
    chk(!sda_oe, "R11 idle after reset", 8'(sda_oe), 8'h00);
    chk_cfg("R5 reset");
    do_read(0, 9, "R5 R6 reset readback");

    // R1 foreign address
    bus_start;
    put_byte(8'hA0, a); chk(!a, "R1 foreign write addr nack", 8'(a), 8'h00);
    put_byte(8'h33, a); chk(!a, "R1 ignored until stop", 8'(a), 8'h00);
    bus_stop;
    bus_start;
    put_byte(8'hD5, a); chk(!a, "R1 foreign read addr nack", 8'(a), 8'h00);
    bus_stop;

    // R2 R3 write with extra bytes
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44; wbuf[4] = 8'h55;
    do_write(2, 3, 5, "R3 extra bytes");
    do_read(2, 4, "R2 R3 readback");

    // R6 R7 read-only fields
    wbuf[0] = 8'hAA; wbuf[1] = 8'hFF; wbuf[2] = 8'hFF;
    do_write(5, 3, 3, "R6 ro write");
    wbuf[0] = 8'hFF;
    do_write(1, 1, 1, "R7 strap write");
    do_read(1, 8, "R6 R7 readback");

    // R8 out of range
    wbuf[0] = 8'h9C; wbuf[1] = 8'h77; wbuf[2] = 8'h66;
    do_write(NR - 1, 3, 3, "R8 edge write");
    do_read(NR - 2, 4, "R8 edge readback");

    // R9 gating by programming enable
    wbuf[0] = 8'hA5;
    do_write(0, 1, 1, "R9 reg0");
    wbuf[0] = 8'h3C; wbuf[1] = 8'hC3;
    do_write(11, 2, 2, "R9 reg11");
    chk_cfg("R9 gated");
    wbuf[0] = 8'h80;
    do_write(10, 1, 1, "R9 enable");
    chk_cfg("R9 open");

    // R4 programmed count
    wbuf[0] = 8'h03;
    do_write(8, 1, 1, "R4 count");
    do_read(0, 3, "R4 count readback");

    // R10 partial byte then stop
    bus_start;
    put_byte(8'hD2, a); put_byte(8'h03, a); put_byte(8'h02, a);
    for (int k = 0; k < 4; k++) put_bit(1'b1);
    bus_stop;
    chk(!sda_oe, "R10 released after partial", 8'(sda_oe), 8'h00);
    do_read(3, 1, "R10 partial dropped");

    // R10 full byte kept, then stop
    bus_start;
    put_byte(8'hD2, a); put_byte(8'h0C, a); put_byte(8'h03, a);
    put_byte(8'h5A, a); model_wr(12, 8'h5A);
    bus_stop;
    do_read(12, 3, "R10 stop kept byte");

    // R10 repeated start restarts framing
    bus_start;
    put_byte(8'hD2, a); put_byte(8'h14, a); put_byte(8'h03, a);
    put_byte(8'hE1, a); model_wr(20, 8'hE1);
    bus_start;
    put_byte(8'hD2, a); chk(a, "R10 restart address ack", 8'(a), 8'h01);
    put_byte(8'h15, a); put_byte(8'h01, a);
    put_byte(8'hE2, a); model_wr(21, 8'hE2);
    put_byte(8'hE3, a);
    bus_stop;
    do_read(20, 3, "R10 restart readback");

    // random block traffic
    for (int it = 0; it < 22; it++) begin
      int idx, n;
      idx = int'($urandom % 30);
      n   = int'($urandom % 5) + 1;
      if (($urandom % 2) == 0) begin
        for (int k = 0; k < 6; k++) wbuf[k] = 8'($urandom);
        do_write(idx, n, n + int'($urandom % 2), "R2 random");
      end else begin
        do_read(idx, n, "R4 random");
      end
    end
    chk_cfg("R9 final");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule